// File: doc/BRIEF.md
# CAN PHY protection and mode controller

This block is the digital control core of a high-speed CAN transceiver. On every clock it decides whether the bus driver may drive a dominant level and what the receive-data pin shows. The inputs are the transmit data line and the mode-select line from the controller, a thermal-fault flag, supply-valid flags for the core rail and the I/O rail, and the receive comparator's bus-dominant indication. Analog sensing and driving are outside the block, and their results arrive as synchronous flags.

Transmit data and mode select pass through a two-flop synchronizer. A dominant-timeout watchdog stops the driver when transmit data stays low for too long. Only a recessive level on transmit data clears it. Silent mode, a thermal fault and a supply fault each take the driver off the bus. The receive path keeps mirroring the bus whenever the core rail is up. When the core rail drops, receive data is held high. When the I/O rail drops, receive data is high-impedance. After both rails return, normal operation resumes only after a programmable restart delay.

Top module: `can_phy_ctrl`

## Requirements
- R1: `txd_i` and `mode_i` reach the control logic through two clock stages, so a change shows at `drv_dom_o` after the second rising edge and not after the first.
- R2: In normal mode (`mode_i`=0) with no fault, `drv_en_o`=1. `drv_dom_o` is 1 when synchronized transmit data is 0 and 0 when it is 1. `drv_dom_o`=1 never occurs without `drv_en_o`=1.
- R3: When synchronized transmit data stays 0 for `DTO_CYCLES` consecutive clocks, the driver is disabled (`drv_en_o`=0, `drv_dom_o`=0). In that case `drv_dom_o` was high for exactly `DTO_CYCLES` cycles.
- R4: After a dominant timeout, the driver stays off while transmit data stays 0. It is re-enabled on the clock after synchronized transmit data returns to 1.
- R5: With `mode_i`=1 (silent), `drv_en_o`=0 and `drv_dom_o`=0. `rxd_o` still mirrors the bus.
- R6: While `therm_fault_i`=1, `drv_en_o`=0 in the same cycle and the receive path stays active. The driver returns in the same cycle the flag drops.
- R7: With `core_ok_i`=0 and `io_ok_i`=1, the driver is off from the next clock. `rxd_o`=1 and `rxd_hiz_o`=0.
- R8: With `io_ok_i`=0, `rxd_hiz_o`=1 at once and the driver is off from the next clock, whatever the core rail does.
- R9: After reset, or after a supply fault, once both rails are valid the driver is enabled only after `RESTART_CYCLES`+1 rising edges.
- R10: While both rails are valid and the restart delay has elapsed, `rxd_o` is 0 when `bus_dom_i`=1 and 1 when `bus_dom_i`=0. This holds in the same cycle and also during a timeout, a thermal fault or silent mode.
- R11: `dto_o`, `tsd_o` and `uvlo_o` are registered levels. Each follows the internal timeout state, the thermal flag and the not-running supply state with one cycle of latency.
- R12: With `DTO_CYCLES`=0 the watchdog is absent, and transmit data held low keeps `drv_dom_o`=1 indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txd_i | input | 1 | Transmit data, 0 = dominant |
| mode_i | input | 1 | Mode select, 0 = normal, 1 = silent |
| therm_fault_i | input | 1 | Thermal-fault flag from the sensor, hysteresis applied by the sensor |
| core_ok_i | input | 1 | Core rail above its undervoltage threshold |
| io_ok_i | input | 1 | I/O rail above its undervoltage threshold |
| bus_dom_i | input | 1 | Comparator reports a dominant bus |
| drv_en_o | output | 1 | Bus driver allowed to drive |
| drv_dom_o | output | 1 | Drive the bus dominant |
| rxd_o | output | 1 | Receive data, 0 = dominant |
| rxd_hiz_o | output | 1 | Receive-data pin to be high-impedance |
| dto_o | output | 1 | Dominant-timeout status |
| tsd_o | output | 1 | Thermal-shutdown status |
| uvlo_o | output | 1 | Undervoltage / restart-pending status |

## Verification
The bench measures the length of a dominant drive to the exact cycle. An off-by-one timeout counter, or a watchdog that restarts while transmit data is still low, shows up as a dominant pulse one cycle too long or short, or as a driver that comes back early. The restart delay is checked one cycle before and one cycle after its end, because a wrongly sized counter would release the driver too soon. The bench tells core-rail and I/O-rail loss apart by the receive pin: a design that confused them would report a driven-high pin where high-impedance is due, or the reverse. A second instance with the watchdog disabled must keep driving through the whole long-dominant test.

// File: rtl/can_phy_pkg.sv
package can_phy_pkg;
  typedef enum logic [1:0] {
    SUP_OFF  = 2'd0,
    SUP_WAIT = 2'd1,
    SUP_RUN  = 2'd2
  } sup_state_e;
endpackage

// File: rtl/can_phy_sync.sv
module can_phy_sync #(
  parameter int unsigned    WIDTH   = 2,
  parameter int unsigned    STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/can_phy_dto.sv
module can_phy_dto #(
  parameter int unsigned TIMEOUT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_i,
  output logic dto_o
);
  if (TIMEOUT == 0) begin : g_off
    assign dto_o = 1'b0;
  end else begin : g_on
    localparam int unsigned CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);
    logic [CW-1:0] cnt_q;
    logic          hit_q;

    // counts consecutive dominant cycles; only recessive clears
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
        hit_q <= 1'b0;
      end else if (txd_i) begin
        cnt_q <= '0;
        hit_q <= 1'b0;
      end else if (!hit_q) begin
        cnt_q <= cnt_q + 1'b1;
        hit_q <= (cnt_q == LAST);
      end
    end

    assign dto_o = hit_q;
  end
endmodule

// File: rtl/can_phy_uvlo.sv
module can_phy_uvlo
  import can_phy_pkg::*;
#(
  parameter int unsigned RESTART = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic core_ok_i,
  input  logic io_ok_i,
  output logic run_o
);
  localparam int unsigned CW = (RESTART > 1) ? $clog2(RESTART) : 1;
  localparam int unsigned LASTI = (RESTART > 0) ? RESTART - 1 : 0;
  localparam logic [CW-1:0] LAST = CW'(LASTI);

  sup_state_e    st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SUP_OFF;
      cnt_q <= '0;
    end else if (!(core_ok_i && io_ok_i)) begin
      st_q  <= SUP_OFF;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        SUP_OFF: begin
          st_q  <= (RESTART == 0) ? SUP_RUN : SUP_WAIT;
          cnt_q <= '0;
        end
        SUP_WAIT: begin
          if (cnt_q == LAST) st_q <= SUP_RUN;
          else               cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= SUP_RUN;
      endcase
    end
  end

  assign run_o = (st_q == SUP_RUN);
endmodule

// File: rtl/can_phy_ctrl.sv
module can_phy_ctrl #(
  parameter int unsigned DTO_CYCLES     = 64,
  parameter int unsigned RESTART_CYCLES = 20,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_i,
  input  logic mode_i,
  input  logic therm_fault_i,
  input  logic core_ok_i,
  input  logic io_ok_i,
  input  logic bus_dom_i,
  output logic drv_en_o,
  output logic drv_dom_o,
  output logic rxd_o,
  output logic rxd_hiz_o,
  output logic dto_o,
  output logic tsd_o,
  output logic uvlo_o
);
  logic [1:0] sync_q;
  logic txd_s, mode_s, dto, run;
  logic dto_q, tsd_q, uvlo_q;

  // bit0 = txd (reset recessive), bit1 = mode (reset normal)
  can_phy_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({mode_i, txd_i}), .q_o(sync_q)
  );
  assign txd_s  = sync_q[0];
  assign mode_s = sync_q[1];

  can_phy_dto #(.TIMEOUT(DTO_CYCLES)) u_dto (
    .clk_i(clk_i), .rst_ni(rst_ni), .txd_i(txd_s), .dto_o(dto)
  );

  can_phy_uvlo #(.RESTART(RESTART_CYCLES)) u_uvlo (
    .clk_i(clk_i), .rst_ni(rst_ni), .core_ok_i(core_ok_i), .io_ok_i(io_ok_i),
    .run_o(run)
  );

  assign drv_en_o  = run && !mode_s && !dto && !therm_fault_i;
  assign drv_dom_o = drv_en_o && !txd_s;
  assign rxd_o     = run ? !bus_dom_i : 1'b1;
  assign rxd_hiz_o = !io_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dto_q  <= 1'b0;
      tsd_q  <= 1'b0;
      uvlo_q <= 1'b1;
    end else begin
      dto_q  <= dto;
      tsd_q  <= therm_fault_i;
      uvlo_q <= !run;
    end
  end

  assign dto_o  = dto_q;
  assign tsd_o  = tsd_q;
  assign uvlo_o = uvlo_q;
endmodule

// File: rtl/can_phy_ctrl_chk.sv
module can_phy_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic txd_i,
  input logic mode_i,
  input logic therm_fault_i,
  input logic core_ok_i,
  input logic io_ok_i,
  input logic bus_dom_i,
  input logic drv_en_o,
  input logic drv_dom_o,
  input logic rxd_o,
  input logic rxd_hiz_o,
  input logic dto_o,
  input logic tsd_o,
  input logic uvlo_o
);
  a_r2_dom_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_dom_o |-> drv_en_o);

  a_r6_thermal_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    therm_fault_i |-> !drv_en_o);

  a_r7_core_uv_rxd_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_ok_i && io_ok_i) |=> (rxd_o && !drv_en_o) || !$past(rst_ni) || core_ok_i);

  a_r8_io_uv_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_ok_i |=> !drv_en_o);

  a_r11_tsd_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (tsd_o == $past(therm_fault_i)));

  a_r11_dto_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dto_o && $past(dto_o) && !txd_i && $past(txd_i == 1'b0)) |-> !drv_dom_o);

  a_r10_rxd_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!uvlo_o && $past(!uvlo_o) && core_ok_i && io_ok_i && $past(core_ok_i && io_ok_i))
      |-> (rxd_o == !bus_dom_i));
endmodule

bind can_phy_ctrl can_phy_ctrl_chk u_chk (.*);

// File: tb/sim_can_phy_ctrl.sv
module sim_can_phy_ctrl;
  localparam int unsigned DTO = 64;
  localparam int unsigned RST_DLY = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic txd = 1'b1, mode = 1'b0, therm = 1'b0, core_ok = 1'b1, io_ok = 1'b1, bus_dom = 1'b0;
  logic drv_en, drv_dom, rxd, rxd_hiz, dto, tsd, uvlo;
  logic drv_en1, drv_dom1, rxd1, rxd_hiz1, dto1, tsd1, uvlo1;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  can_phy_ctrl #(.DTO_CYCLES(DTO), .RESTART_CYCLES(RST_DLY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .txd_i(txd), .mode_i(mode), .therm_fault_i(therm),
    .core_ok_i(core_ok), .io_ok_i(io_ok), .bus_dom_i(bus_dom),
    .drv_en_o(drv_en), .drv_dom_o(drv_dom), .rxd_o(rxd), .rxd_hiz_o(rxd_hiz),
    .dto_o(dto), .tsd_o(tsd), .uvlo_o(uvlo));

  can_phy_ctrl #(.DTO_CYCLES(0), .RESTART_CYCLES(RST_DLY)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .txd_i(txd), .mode_i(mode), .therm_fault_i(therm),
    .core_ok_i(core_ok), .io_ok_i(io_ok), .bus_dom_i(bus_dom),
    .drv_en_o(drv_en1), .drv_dom_o(drv_dom1), .rxd_o(rxd1), .rxd_hiz_o(rxd_hiz1),
    .dto_o(dto1), .tsd_o(tsd1), .uvlo_o(uvlo1));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    wait_n(2);
    chk("R9 reset drv_en", drv_en, 1'b0);
    chk("R11 reset uvlo", uvlo, 1'b1);
    chk("R7 reset rxd high", rxd, 1'b1);
    chk("R11 reset dto", dto, 1'b0);
    rst_n = 1'b1;
    wait_n(RST_DLY);
    chk("R9 restart not early", drv_en, 1'b0);
    wait_n(1);
    chk("R9 restart done", drv_en, 1'b1);
    chk("R11 uvlo lag", uvlo, 1'b1);
    wait_n(1);
    chk("R11 uvlo clear", uvlo, 1'b0);
  endtask

  task automatic t_sync_drive;
    txd = 1'b0;
    wait_n(1);
    chk("R1 one stage only", drv_dom, 1'b0);
    wait_n(1);
    chk("R2 dominant", drv_dom, 1'b1);
    chk("R2 enabled", drv_en, 1'b1);
    txd = 1'b1;
    wait_n(1);
    chk("R1 recessive delayed", drv_dom, 1'b1);
    wait_n(1);
    chk("R2 recessive", drv_dom, 1'b0);
    bus_dom = 1'b1; #1;
    chk("R10 rxd dominant", rxd, 1'b0);
    bus_dom = 1'b0; #1;
    chk("R10 rxd recessive", rxd, 1'b1);
  endtask

  task automatic t_timeout;
    txd = 1'b0;
    wait_n(DTO + 1);
    chk("R3 still driving", drv_dom, 1'b1);
    wait_n(1);
    chk("R3 timed out dom", drv_dom, 1'b0);
    chk("R3 timed out en", drv_en, 1'b0);
    chk("R11 dto lag", dto, 1'b0);
    chk("R12 no watchdog", drv_dom1, 1'b1);
    wait_n(1);
    chk("R11 dto set", dto, 1'b1);
    wait_n(10);
    chk("R4 held off while low", drv_en, 1'b0);
    chk("R12 still driving", drv_dom1, 1'b1);
    bus_dom = 1'b1; #1;
    chk("R10 rxd during timeout", rxd, 1'b0);
    bus_dom = 1'b0;
    txd = 1'b1;
    wait_n(2);
    chk("R4 not before clear", drv_en, 1'b0);
    wait_n(1);
    chk("R4 re-enabled", drv_en, 1'b1);
    chk("R4 recessive after clear", drv_dom, 1'b0);
  endtask

  task automatic t_silent;
    mode = 1'b1; txd = 1'b0;
    wait_n(2);
    chk("R5 silent en", drv_en, 1'b0);
    chk("R5 silent dom", drv_dom, 1'b0);
    bus_dom = 1'b1; #1;
    chk("R5 silent rxd", rxd, 1'b0);
    bus_dom = 1'b0;
    txd = 1'b1; mode = 1'b0;
    wait_n(2);
    chk("R5 back to normal", drv_en, 1'b1);
  endtask

  task automatic t_thermal;
    therm = 1'b1; #1;
    chk("R6 thermal off", drv_en, 1'b0);
    txd = 1'b0;
    wait_n(2);
    chk("R6 no dominant", drv_dom, 1'b0);
    chk("R11 tsd set", tsd, 1'b1);
    bus_dom = 1'b1; #1;
    chk("R6 rxd active", rxd, 1'b0);
    bus_dom = 1'b0;
    therm = 1'b0; #1;
    chk("R6 resumes", drv_dom, 1'b1);
    wait_n(1);
    chk("R11 tsd clear", tsd, 1'b0);
    txd = 1'b1;
    wait_n(3);
  endtask

  task automatic t_core_uv;
    core_ok = 1'b0; bus_dom = 1'b1;
    wait_n(1);
    chk("R7 driver off", drv_en, 1'b0);
    chk("R7 rxd high", rxd, 1'b1);
    chk("R7 not hiz", rxd_hiz, 1'b0);
    wait_n(1);
    chk("R11 uvlo set", uvlo, 1'b1);
    bus_dom = 1'b0; core_ok = 1'b1;
    wait_n(RST_DLY);
    chk("R9 core restart early", drv_en, 1'b0);
    wait_n(1);
    chk("R9 core restart done", drv_en, 1'b1);
  endtask

  task automatic t_io_uv;
    io_ok = 1'b0; #1;
    chk("R8 hiz now", rxd_hiz, 1'b1);
    wait_n(1);
    chk("R8 driver off", drv_en, 1'b0);
    core_ok = 1'b0;
    wait_n(1);
    chk("R8 hiz any core", rxd_hiz, 1'b1);
    core_ok = 1'b1; io_ok = 1'b1; #1;
    chk("R8 hiz released", rxd_hiz, 1'b0);
    wait_n(RST_DLY + 1);
    chk("R9 io restart done", drv_en, 1'b1);
  endtask

  initial begin
    t_reset();
    t_sync_drive();
    t_timeout();
    t_silent();
    t_thermal();
    t_core_uv();
    t_io_uv();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule